// File: doc/BRIEF.md
# Remote Terminal Subsystem Transfer Sequencer

This block is the subsystem-facing control of a serial-bus remote terminal. A front end that has already decoded and validated a command word hands it over as a one-cycle strobe together with the transmit/receive bit, the 5-bit subaddress and the 5-bit word count. The sequencer checks the parity of the terminal address. It marks acceptance with a short active-low start pulse, captures the terminal-flag input into a status word and drives a 10-bit address bus. It then moves the commanded number of data words across a request/grant/acknowledge handshake.

The upper half of the address bus always carries the latched subaddress. The lower half carries the running word index while a data-carrying command is in progress. In every other case it carries the latched word-count field. A direction output tells the external data buffers whether words are being read from the subsystem (transmit) or written to it (receive). After a receive command finishes cleanly, an active-low good-block pulse tells the subsystem that the whole block has been delivered.

Top module: `rtseq_top`

## Requirements
- R1: A command strobe is accepted only if the five terminal-address bits plus the parity input hold an odd number of ones. With even parity the strobe is ignored: no start pulse, no handshake, and no change to the address bus or the status word.
- R2: Accepting a command drives newSeqN low for exactly 3 clock cycles, beginning the cycle after the strobe.
- R3: addrOut[9:5] holds the subaddress latched at the last accepted command and changes only on acceptance.
- R4: addrOut[4:0] shows the latched word-count field while no sequence is in progress. It also shows it for the whole of a mode command, which is one whose subaddress is 5'b00000 or 5'b11111. A mode command performs no data transfers.
- R5: During a non-mode command, addrOut[4:0] shows the running word index, starting at 0 and advancing by one after each acknowledged transfer.
- R6: xferReqN is low while the block waits for a word. One cycle after xferGrantN is sampled low, xferAckN goes low for exactly one cycle and xferReqN is high. Request and acknowledge are never low together.
- R7: The sequence ends after the commanded number of transfers, where a word-count field of 0 means 32 words. After that, xferReqN stays high.
- R8: dirRead is 0 after reset. It goes to 1 in the cycle after a non-mode transmit command is accepted and returns to 0 in the cycle after the last transfer. Receive commands leave it at 0.
- R9: When a non-mode receive sequence completes and msgErr was never high during it, goodBlkN goes low for exactly 8 cycles, starting the cycle after the last transfer. Transmit commands and receive commands that saw msgErr produce no pulse.
- R10: On acceptance, stsWord[0] is loaded with 1 if flagInN is low and with 0 if it is high. stsWord[15:11] is loaded with the terminal address, and the remaining bits are 0.
- R11: While rstN is low, the block is idle: addrOut, stsWord and dirRead are 0, and newSeqN, goodBlkN, xferReqN and xferAckN are 1.
- R12: A command strobe that arrives while a sequence or a start pulse is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rstN | input | 1 | Active-low reset |
| cmdStb | input | 1 | One-cycle strobe for a validated command word |
| cmdTx | input | 1 | 1 = transmit command, 0 = receive |
| cmdSub | input | 5 | Subaddress field of the command |
| cmdWc | input | 5 | Word-count field of the command (0 means 32) |
| tAddr | input | 5 | Assigned terminal address |
| tAddrPar | input | 1 | Parity bit for the terminal address |
| flagInN | input | 1 | Terminal-flag request, active low |
| msgErr | input | 1 | Message error indication from the front end |
| xferGrantN | input | 1 | Subsystem grant for a word transfer, active low |
| addrOut | output | 10 | Subaddress and word-count or word-index address |
| dirRead | output | 1 | 1 = reading words from the subsystem |
| xferReqN | output | 1 | Word transfer request, active low |
| xferAckN | output | 1 | Word transfer in progress, active low |
| newSeqN | output | 1 | Start-of-sequence pulse, active low |
| goodBlkN | output | 1 | Good receive block pulse, active low |
| stsWord | output | 16 | Status word: terminal address and flag bit |

## Verification
The checker assumes that the subsystem drives xferGrantN low only while a request is outstanding. It also assumes that command strobes come from the validated front end, one cycle at a time. The bench holds to this by asserting the grant only after it has seen xferReqN low at a falling edge, and by releasing the grant in the acknowledge cycle. It also pulses cmdStb for a single cycle, and it pulses msgErr only inside an active receive sequence.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic latchCmd;
    logic fireNewSeq;
    logic incCnt;
    logic fireGood;
    logic clrDir;
  } seqStrobe_t;
endpackage

// File: rtl/rtseq_ctrl.sv
module rtseq_ctrl
  import rtseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStb,
  input  logic       parityOk,
  input  logic       inModeCmd,
  input  logic       newSeqBusy,
  input  logic       lastWord,
  input  logic       txLat,
  input  logic       errSeen,
  input  logic       msgErr,
  input  logic       xferGrantN,
  output seqStrobe_t strobe,
  output logic       active,
  output logic       xferReqN,
  output logic       xferAckN
);
  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStb && parityOk && !newSeqBusy) begin
          strobe.latchCmd   = 1'b1;
          strobe.fireNewSeq = 1'b1;
          if (!inModeCmd) stateNxt = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!xferGrantN) stateNxt = ST_ACK;
      end
      ST_ACK: begin
        strobe.incCnt = 1'b1;
        if (lastWord) begin
          stateNxt        = ST_IDLE;
          strobe.clrDir   = 1'b1;
          strobe.fireGood = !txLat && !errSeen && !msgErr;
        end else begin
          stateNxt = ST_REQ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign active   = (state != ST_IDLE);
  assign xferReqN = (state != ST_REQ);
  assign xferAckN = (state != ST_ACK);
endmodule

// File: rtl/rtseq_dpath.sv
module rtseq_dpath
  import rtseq_pkg::*;
#(
  parameter int SUB_W      = 5,
  parameter int WC_W       = 5,
  parameter int TADDR_W    = 5,
  parameter int STS_W      = 16,
  parameter int NEWSEQ_CYC = 3,
  parameter int GOOD_CYC   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic                    active,
  input  logic                    cmdTx,
  input  logic [SUB_W-1:0]        cmdSub,
  input  logic [WC_W-1:0]         cmdWc,
  input  logic [TADDR_W-1:0]      tAddr,
  input  logic                    tAddrPar,
  input  logic                    flagInN,
  input  logic                    msgErr,
  output logic                    parityOk,
  output logic                    inModeCmd,
  output logic                    newSeqBusy,
  output logic                    lastWord,
  output logic                    txLat,
  output logic                    errSeen,
  output logic [SUB_W+WC_W-1:0]   addrOut,
  output logic                    dirRead,
  output logic                    newSeqN,
  output logic                    goodBlkN,
  output logic [STS_W-1:0]        stsWord
);
  localparam int CNT_W  = WC_W + 1;
  localparam int NS_W   = $clog2(NEWSEQ_CYC + 1);
  localparam int GB_W   = $clog2(GOOD_CYC + 1);
  localparam int PAD_W  = STS_W - TADDR_W - 1;

  logic [SUB_W-1:0]   subLat;
  logic [WC_W-1:0]    wcLat;
  logic               modeLat;
  logic [CNT_W-1:0]   wordCnt;
  logic [CNT_W-1:0]   wcTarget;
  logic [NS_W-1:0]    newCnt;
  logic [GB_W-1:0]    goodCnt;
  logic [TADDR_W-1:0] tAddrLat;
  logic               flagBit;

  assign parityOk   = ^{tAddr, tAddrPar};
  assign inModeCmd  = (cmdSub == '0) || (cmdSub == '1);
  assign newSeqBusy = (newCnt != '0);
  assign wcTarget   = {(wcLat == '0), wcLat};
  assign lastWord   = ((wordCnt + CNT_W'(1)) == wcTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subLat   <= '0;
      wcLat    <= '0;
      modeLat  <= 1'b0;
      txLat    <= 1'b0;
      tAddrLat <= '0;
      flagBit  <= 1'b0;
    end else if (strobe.latchCmd) begin
      subLat   <= cmdSub;
      wcLat    <= cmdWc;
      modeLat  <= inModeCmd;
      txLat    <= cmdTx;
      tAddrLat <= tAddr;
      flagBit  <= !flagInN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wordCnt <= '0;
    else if (strobe.latchCmd)  wordCnt <= '0;
    else if (strobe.incCnt)    wordCnt <= wordCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        errSeen <= 1'b0;
    else if (strobe.latchCmd)         errSeen <= 1'b0;
    else if (active && msgErr)        errSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    dirRead <= 1'b0;
    else if (strobe.latchCmd && cmdTx && !inModeCmd) dirRead <= 1'b1;
    else if (strobe.clrDir)                       dirRead <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  newCnt <= '0;
    else if (strobe.fireNewSeq) newCnt <= NS_W'(NEWSEQ_CYC);
    else if (newCnt != '0)      newCnt <= newCnt - NS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                goodCnt <= '0;
    else if (strobe.fireGood) goodCnt <= GB_W'(GOOD_CYC);
    else if (goodCnt != '0)   goodCnt <= goodCnt - GB_W'(1);
  end

  assign newSeqN  = (newCnt == '0);
  assign goodBlkN = (goodCnt == '0);
  assign addrOut  = {subLat, (active && !modeLat) ? wordCnt[WC_W-1:0] : wcLat};
  assign stsWord  = {tAddrLat, {PAD_W{1'b0}}, flagBit};
endmodule

// File: rtl/rtseq_top.sv
module rtseq_top
  import rtseq_pkg::*;
#(
  parameter int SUB_W      = 5,
  parameter int WC_W       = 5,
  parameter int TADDR_W    = 5,
  parameter int STS_W      = 16,
  parameter int NEWSEQ_CYC = 3,
  parameter int GOOD_CYC   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdStb,
  input  logic                  cmdTx,
  input  logic [SUB_W-1:0]      cmdSub,
  input  logic [WC_W-1:0]       cmdWc,
  input  logic [TADDR_W-1:0]    tAddr,
  input  logic                  tAddrPar,
  input  logic                  flagInN,
  input  logic                  msgErr,
  input  logic                  xferGrantN,
  output logic [SUB_W+WC_W-1:0] addrOut,
  output logic                  dirRead,
  output logic                  xferReqN,
  output logic                  xferAckN,
  output logic                  newSeqN,
  output logic                  goodBlkN,
  output logic [STS_W-1:0]      stsWord
);
  seqStrobe_t strobe;
  logic active, parityOk, inModeCmd, newSeqBusy, lastWord, txLat, errSeen;

  rtseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .parityOk(parityOk),
    .inModeCmd(inModeCmd), .newSeqBusy(newSeqBusy), .lastWord(lastWord),
    .txLat(txLat), .errSeen(errSeen), .msgErr(msgErr),
    .xferGrantN(xferGrantN), .strobe(strobe), .active(active),
    .xferReqN(xferReqN), .xferAckN(xferAckN)
  );

  rtseq_dpath #(
    .SUB_W(SUB_W), .WC_W(WC_W), .TADDR_W(TADDR_W), .STS_W(STS_W),
    .NEWSEQ_CYC(NEWSEQ_CYC), .GOOD_CYC(GOOD_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(active),
    .cmdTx(cmdTx), .cmdSub(cmdSub), .cmdWc(cmdWc), .tAddr(tAddr),
    .tAddrPar(tAddrPar), .flagInN(flagInN), .msgErr(msgErr),
    .parityOk(parityOk), .inModeCmd(inModeCmd), .newSeqBusy(newSeqBusy),
    .lastWord(lastWord), .txLat(txLat), .errSeen(errSeen),
    .addrOut(addrOut), .dirRead(dirRead), .newSeqN(newSeqN),
    .goodBlkN(goodBlkN), .stsWord(stsWord)
  );
endmodule

// File: rtl/rtseq_chk.sv
module rtseq_chk #(
  parameter int SUB_W      = 5,
  parameter int WC_W       = 5,
  parameter int TADDR_W    = 5,
  parameter int NEWSEQ_CYC = 3,
  parameter int GOOD_CYC   = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cmdStb,
  input logic                  cmdTx,
  input logic [TADDR_W-1:0]    tAddr,
  input logic                  tAddrPar,
  input logic                  xferGrantN,
  input logic [SUB_W+WC_W-1:0] addrOut,
  input logic                  dirRead,
  input logic                  xferReqN,
  input logic                  xferAckN,
  input logic                  newSeqN,
  input logic                  goodBlkN
);
  logic [15:0] nsLow, gbLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsLow <= '0;
      gbLow <= '0;
    end else begin
      nsLow <= newSeqN  ? 16'd0 : nsLow + 16'd1;
      gbLow <= goodBlkN ? 16'd0 : gbLow + 16'd1;
    end
  end

  // R1
  parity_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(newSeqN) |-> $past(cmdStb && (^{tAddr, tAddrPar})));

  // R2
  newseq_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (newSeqN && nsLow != 16'd0) |-> (nsLow == 16'(NEWSEQ_CYC)));

  // R3
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(newSeqN) |-> $stable(addrOut[SUB_W+WC_W-1:WC_W]));

  // R4
  mode_no_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferReqN |-> !((addrOut[SUB_W+WC_W-1:WC_W] == '0) ||
                    (addrOut[SUB_W+WC_W-1:WC_W] == '1)));

  // R6
  ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferAckN) |-> $past(!xferGrantN && !xferReqN));

  // R6
  req_ack_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!xferReqN && !xferAckN));

  // R8
  dir_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dirRead) |-> $past(cmdStb && cmdTx));

  // R9
  good_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodBlkN && gbLow != 16'd0) |-> (gbLow == 16'(GOOD_CYC)));

  // R9
  good_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goodBlkN) |-> $past(!xferAckN && !dirRead));
endmodule

bind rtseq_top rtseq_chk #(
  .SUB_W(SUB_W), .WC_W(WC_W), .TADDR_W(TADDR_W),
  .NEWSEQ_CYC(NEWSEQ_CYC), .GOOD_CYC(GOOD_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .cmdTx(cmdTx), .tAddr(tAddr),
  .tAddrPar(tAddrPar), .xferGrantN(xferGrantN), .addrOut(addrOut),
  .dirRead(dirRead), .xferReqN(xferReqN), .xferAckN(xferAckN),
  .newSeqN(newSeqN), .goodBlkN(goodBlkN)
);

// File: tb/tb_rtseq_top.sv
module tb_rtseq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdStb = 1'b0, cmdTx = 1'b0;
  logic [4:0] cmdSub = '0, cmdWc = '0;
  logic [4:0] tAddr = 5'b00101;
  logic       tAddrPar = 1'b1;
  logic       flagInN = 1'b1, msgErr = 1'b0, xferGrantN = 1'b1;
  logic [9:0] addrOut;
  logic       dirRead, xferReqN, xferAckN, newSeqN, goodBlkN;
  logic [15:0] stsWord;

  int nChecks = 0;
  int nErrs   = 0;

  always #2 clk = ~clk;

  rtseq_top dut (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .cmdTx(cmdTx), .cmdSub(cmdSub),
    .cmdWc(cmdWc), .tAddr(tAddr), .tAddrPar(tAddrPar), .flagInN(flagInN),
    .msgErr(msgErr), .xferGrantN(xferGrantN), .addrOut(addrOut),
    .dirRead(dirRead), .xferReqN(xferReqN), .xferAckN(xferAckN),
    .newSeqN(newSeqN), .goodBlkN(goodBlkN), .stsWord(stsWord)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a strobe; returns at the falling edge after the accepting edge.
  task automatic issueCmd(input bit tx, input [4:0] sub, input [4:0] wc,
                          input [4:0] ta, input bit par, input bit flN);
    @(negedge clk);
    cmdStb = 1'b1; cmdTx = tx; cmdSub = sub; cmdWc = wc;
    tAddr = ta; tAddrPar = par; flagInN = flN;
    @(negedge clk);
    cmdStb = 1'b0;
  endtask

  task automatic doWords(input int n, input bit tx, input int errAt);
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      while (xferReqN && guard < 20) begin @(negedge clk); guard++; end
      chk(!xferReqN, "R6", "request pending", xferReqN, 0);
      chk(addrOut[4:0] == 5'(i), "R5", "index while waiting", addrOut[4:0], i);
      repeat (i % 3) @(negedge clk);
      xferGrantN = 1'b0;
      if (i == errAt) msgErr = 1'b1;
      @(negedge clk);
      xferGrantN = 1'b1;
      msgErr = 1'b0;
      chk(!xferAckN && xferReqN, "R6", "ack after grant",
          {xferAckN, xferReqN}, 2'b01);
      chk(addrOut[4:0] == 5'(i), "R5", "index during ack", addrOut[4:0], i);
      chk(dirRead == tx, "R8", "direction during transfer", dirRead, tx);
    end
    @(negedge clk);
    chk(xferReqN, "R7", "sequence ended", xferReqN, 1);
    chk(dirRead == 1'b0, "R8", "direction after last word", dirRead, 0);
  endtask

  task automatic goodLen(output int c);
    c = 0;
    while (!goodBlkN && c < 40) begin c++; @(negedge clk); end
  endtask

  task automatic tReset;
    chk(addrOut == 0 && stsWord == 0 && dirRead == 0, "R11", "reset data",
        {addrOut, stsWord, dirRead}, 0);
    chk({newSeqN, goodBlkN, xferReqN, xferAckN} == 4'hF, "R11", "reset strobes",
        {newSeqN, goodBlkN, xferReqN, xferAckN}, 15);
  endtask

  task automatic tModeCmd;
    int low = 0;
    issueCmd(1'b1, 5'd31, 5'd5, 5'b00101, 1'b1, 1'b0);
    chk(addrOut == {5'd31, 5'd5}, "R4", "mode address", addrOut, {5'd31, 5'd5});
    chk(stsWord == {5'b00101, 10'd0, 1'b1}, "R10", "flag set", stsWord,
        {5'b00101, 10'd0, 1'b1});
    while (!newSeqN && low < 10) begin low++; @(negedge clk); end
    chk(low == 3, "R2", "start pulse width", low, 3);
    chk(xferReqN && !dirRead, "R4", "mode command no transfer",
        {xferReqN, dirRead}, 2'b10);
    chk(addrOut[4:0] == 5'd5, "R4", "wc field after mode", addrOut[4:0], 5);
  endtask

  task automatic tBadParity;
    issueCmd(1'b0, 5'd7, 5'd2, 5'b00001, 1'b1, 1'b1);
    chk(newSeqN, "R1", "no start pulse on bad parity", newSeqN, 1);
    repeat (3) @(negedge clk);
    chk(xferReqN && addrOut == {5'd31, 5'd5}, "R1", "address unchanged",
        addrOut, {5'd31, 5'd5});
    chk(stsWord[0] == 1'b1, "R1", "status unchanged", stsWord[0], 1);
  endtask

  task automatic tRxGood;
    int c;
    issueCmd(1'b0, 5'd3, 5'd4, 5'b00001, 1'b0, 1'b1);
    chk(!newSeqN, "R2", "start pulse after accept", newSeqN, 0);
    chk(addrOut[9:5] == 5'd3, "R3", "latched subaddress", addrOut[9:5], 3);
    chk(stsWord == {5'b00001, 10'd0, 1'b0}, "R10", "flag clear", stsWord,
        {5'b00001, 10'd0, 1'b0});
    doWords(4, 1'b0, -1);
    goodLen(c);
    chk(c == 8, "R9", "good block width", c, 8);
    chk(addrOut == {5'd3, 5'd4}, "R4", "wc field when idle", addrOut,
        {5'd3, 5'd4});
  endtask

  task automatic tRxErr;
    int c;
    issueCmd(1'b0, 5'd12, 5'd3, 5'b00101, 1'b1, 1'b1);
    doWords(3, 1'b0, 1);
    goodLen(c);
    chk(c == 0, "R9", "no good block after error", c, 0);
  endtask

  task automatic tTx32;
    int c;
    issueCmd(1'b1, 5'd17, 5'd0, 5'b00101, 1'b1, 1'b1);
    chk(dirRead, "R8", "read after transmit accept", dirRead, 1);
    doWords(32, 1'b1, -1);
    goodLen(c);
    chk(c == 0, "R9", "no good block on transmit", c, 0);
    chk(addrOut == {5'd17, 5'd0}, "R7", "32-word end, wc field", addrOut,
        {5'd17, 5'd0});
  endtask

  task automatic tBusyIgnore;
    int c;
    issueCmd(1'b0, 5'd4, 5'd2, 5'b00101, 1'b1, 1'b1);
    cmdStb = 1'b1; cmdSub = 5'd9; cmdWc = 5'd7; cmdTx = 1'b1;
    @(negedge clk);
    cmdStb = 1'b0;
    chk(addrOut[9:5] == 5'd4 && !dirRead, "R12", "strobe ignored while busy",
        addrOut[9:5], 4);
    doWords(2, 1'b0, -1);
    goodLen(c);
    chk(c == 8, "R12", "first sequence completes", c, 8);
  endtask

  initial begin
    #600000;
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tModeCmd();
    tBadParity();
    tRxGood();
    tRxErr();
    tTx32();
    tBusyIgnore();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule